// File: doc/BRIEF.md
# On-chip data space router with stack path

This block owns the internal data RAM of an 8-bit controller and steers every data access to the right storage. The addresses 80H–FFH have two meanings. Direct addressing reaches the peripheral register space. Indirect addressing reaches a second, physically separate bank of RAM. Addresses below 80H always reach the lower RAM bank, whatever the mode.

The CPU side presents a byte address, a mode flag, read and write strobes, and write data. It gets read data back in the same cycle. Direct accesses to the upper half leave the block on a peripheral register bus. That bus carries the address, the strobes and the write data outward, and it returns read data with a claim flag.

The block also keeps the stack pointer. A push or a pop is an indirect access, so the stack can grow into the upper RAM bank.

Top module: `dspace_router`

## Requirements
- R1: Addresses 00H–7FH reach the lower RAM bank in both modes: a byte written in direct mode reads back in indirect mode, and the reverse.
- R2: A direct access (`acc_indirect`=0) to an address with bit 7 set is sent out on the register bus. `sfr_addr` equals the address, `sfr_rd`/`sfr_wr` follow the strobes, `sfr_wdata` carries the data, and no RAM byte is written.
- R3: An indirect access (`acc_indirect`=1) to an address with bit 7 set reads or writes the upper RAM bank, and both register bus strobes stay low.
- R4: The upper RAM bank and the register space are separate storage. After an indirect write of X to A0H and a direct write of Y to A0H, an indirect read of A0H returns X and a direct read returns Y.
- R5: A direct read of the upper half returns `sfr_rdata` when `sfr_hit` is 1, and returns 00H when no register claims the address.
- R6: RAM writes take effect at the rising clock edge. Reads are combinational, so a read in the cycle after a write returns the new byte within that cycle.
- R7: Reset (synchronous, active high) sets the stack pointer `stk_ptr` to 07H.
- R8: A push (`stk_push`=1) writes `acc_wdata` to RAM at `stk_ptr`+1, and `stk_ptr` becomes `stk_ptr`+1 after the edge.
- R9: A pop (`stk_pop`=1) returns RAM[`stk_ptr`] on `rd_data` in the same cycle, and `stk_ptr` becomes `stk_ptr`−1 after the edge.
- R10: The stack pointer wraps modulo 256. A push at FFH writes address 00H and leaves 00H, and a pop at 00H leaves FFH.
- R11: The priority is push, then pop, then the plain access. A plain access in the same cycle as a stack operation writes nothing and raises no register bus strobe.
- R12: `rd_data` is 00H in any cycle with neither a read nor a pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_addr | input | 8 | Byte address of the plain access |
| acc_indirect | input | 1 | 1 = indirect mode, 0 = direct mode |
| acc_rd | input | 1 | Read strobe |
| acc_wr | input | 1 | Write strobe |
| acc_wdata | input | 8 | Write data, also the push data |
| stk_push | input | 1 | Push request |
| stk_pop | input | 1 | Pop request |
| rd_data | output | 8 | Read or pop data, combinational |
| stk_ptr | output | 8 | Current stack pointer |
| sfr_addr | output | 8 | Register bus address |
| sfr_rd | output | 1 | Register bus read strobe |
| sfr_wr | output | 1 | Register bus write strobe |
| sfr_wdata | output | 8 | Register bus write data |
| sfr_rdata | input | 8 | Register bus read data |
| sfr_hit | input | 1 | A register claims `sfr_addr` |

## Verification
The routing is tried with one address, A0H, written and read in both modes. Only separate storage gives two different values back, so this tells a shared array from two distinct ones. A claimed address and an unclaimed one in the upper half, read directly, tell the hit path from the 00H fill. The lower-half cross-mode pairs show that the mode bit is ignored below 80H. Stack tests walk the pointer through FFH and 00H in both directions, and they collide a stack operation with a direct register write to show that the priority suppresses the plain access.

// File: rtl/dspace_pkg.sv
package dspace_pkg;

    // Which path serves the current cycle
    typedef enum logic [2:0] {
        RT_IDLE,
        RT_LOW_RAM,
        RT_HIGH_RAM,
        RT_SFR,
        RT_PUSH,
        RT_POP
    } route_e;

    // Stack side effect requested of the pointer
    typedef struct packed {
        logic inc;
        logic dec;
    } sp_step_t;

    // Priority: push, pop, then the plain access split by half and mode
    function automatic route_e pick_route(
        input logic push,
        input logic pop,
        input logic rd,
        input logic wr,
        input logic indirect,
        input logic upper
    );
        if (push)             return RT_PUSH;
        else if (pop)         return RT_POP;
        else if (!(rd || wr)) return RT_IDLE;
        else if (!upper)      return RT_LOW_RAM;
        else if (indirect)    return RT_HIGH_RAM;
        else                  return RT_SFR;
    endfunction

endpackage

// File: rtl/dspace_ram.sv
module dspace_ram #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int unsigned BANKS      = 2;
    localparam int unsigned BANK_DEPTH = (1 << ADDR_W) / BANKS;
    localparam int unsigned OFF_W      = ADDR_W - 1;

    logic [DATA_W-1:0] bank_rd [BANKS];

    // Lower and upper halves are separate arrays, selected by the address MSB
    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic [DATA_W-1:0] mem [BANK_DEPTH];

        always_ff @(posedge clk) begin
            if (we && (waddr[ADDR_W-1] == 1'(b))) begin
                mem[waddr[OFF_W-1:0]] <= wdata;
            end
        end

        assign bank_rd[b] = mem[raddr[OFF_W-1:0]];
    end

    assign rdata = bank_rd[raddr[ADDR_W-1]];

endmodule

// File: rtl/dspace_sp.sv
module dspace_sp
    import dspace_pkg::*;
#(
    parameter int unsigned       ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] SP_RESET = 'h07
) (
    input  logic              clk,
    input  logic              rst,
    input  sp_step_t          step,
    output logic [ADDR_W-1:0] sp,
    output logic [ADDR_W-1:0] sp_up
);
    assign sp_up = sp + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            sp <= SP_RESET;
        end else if (step.inc) begin
            sp <= sp_up;
        end else if (step.dec) begin
            sp <= sp - 1'b1;
        end
    end

endmodule

// File: rtl/dspace_route.sv
module dspace_route
    import dspace_pkg::*;
#(
    parameter int unsigned       ADDR_W   = 8,
    parameter int unsigned       DATA_W   = 8,
    parameter logic [DATA_W-1:0] FILL_VAL = '0
) (
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_indirect,
    input  logic              acc_rd,
    input  logic              acc_wr,
    input  logic [DATA_W-1:0] acc_wdata,
    input  logic              stk_push,
    input  logic              stk_pop,
    input  logic [ADDR_W-1:0] sp,
    input  logic [ADDR_W-1:0] sp_up,
    input  logic [DATA_W-1:0] ram_rdata,
    input  logic [DATA_W-1:0] sfr_rdata,
    input  logic              sfr_hit,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_waddr,
    output logic [ADDR_W-1:0] ram_raddr,
    output logic [DATA_W-1:0] ram_wdata,
    output sp_step_t          step,
    output logic [ADDR_W-1:0] sfr_addr,
    output logic              sfr_rd,
    output logic              sfr_wr,
    output logic [DATA_W-1:0] sfr_wdata,
    output logic [DATA_W-1:0] rd_data
);
    route_e route;

    always_comb begin
        route     = pick_route(stk_push, stk_pop, acc_rd, acc_wr,
                               acc_indirect, acc_addr[ADDR_W-1]);
        ram_we    = 1'b0;
        ram_waddr = acc_addr;
        ram_raddr = acc_addr;
        ram_wdata = acc_wdata;
        step      = '0;
        sfr_addr  = '0;
        sfr_rd    = 1'b0;
        sfr_wr    = 1'b0;
        sfr_wdata = '0;
        rd_data   = FILL_VAL;

        unique case (route)
            RT_PUSH: begin
                ram_we    = 1'b1;
                ram_waddr = sp_up;
                step.inc  = 1'b1;
            end
            RT_POP: begin
                ram_raddr = sp;
                rd_data   = ram_rdata;
                step.dec  = 1'b1;
            end
            RT_LOW_RAM, RT_HIGH_RAM: begin
                ram_we = acc_wr;
                if (acc_rd) rd_data = ram_rdata;
            end
            RT_SFR: begin
                sfr_addr  = acc_addr;
                sfr_rd    = acc_rd;
                sfr_wr    = acc_wr;
                sfr_wdata = acc_wdata;
                if (acc_rd && sfr_hit) rd_data = sfr_rdata;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/dspace_router.sv
module dspace_router
    import dspace_pkg::*;
#(
    parameter int unsigned       ADDR_W   = 8,
    parameter int unsigned       DATA_W   = 8,
    parameter logic [ADDR_W-1:0] SP_RESET = 'h07,
    parameter logic [DATA_W-1:0] FILL_VAL = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_indirect,
    input  logic              acc_rd,
    input  logic              acc_wr,
    input  logic [DATA_W-1:0] acc_wdata,
    input  logic              stk_push,
    input  logic              stk_pop,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] stk_ptr,
    output logic [ADDR_W-1:0] sfr_addr,
    output logic              sfr_rd,
    output logic              sfr_wr,
    output logic [DATA_W-1:0] sfr_wdata,
    input  logic [DATA_W-1:0] sfr_rdata,
    input  logic              sfr_hit
);
    logic              ram_we;
    logic [ADDR_W-1:0] ram_waddr;
    logic [ADDR_W-1:0] ram_raddr;
    logic [DATA_W-1:0] ram_wdata;
    logic [DATA_W-1:0] ram_rdata;
    logic [ADDR_W-1:0] sp_up;
    sp_step_t          step;

    dspace_sp #(.ADDR_W(ADDR_W), .SP_RESET(SP_RESET)) u_sp (
        .clk   (clk),
        .rst   (rst),
        .step  (step),
        .sp    (stk_ptr),
        .sp_up (sp_up)
    );

    dspace_route #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .FILL_VAL(FILL_VAL)) u_route (
        .acc_addr     (acc_addr),
        .acc_indirect (acc_indirect),
        .acc_rd       (acc_rd),
        .acc_wr       (acc_wr),
        .acc_wdata    (acc_wdata),
        .stk_push     (stk_push),
        .stk_pop      (stk_pop),
        .sp           (stk_ptr),
        .sp_up        (sp_up),
        .ram_rdata    (ram_rdata),
        .sfr_rdata    (sfr_rdata),
        .sfr_hit      (sfr_hit),
        .ram_we       (ram_we),
        .ram_waddr    (ram_waddr),
        .ram_raddr    (ram_raddr),
        .ram_wdata    (ram_wdata),
        .step         (step),
        .sfr_addr     (sfr_addr),
        .sfr_rd       (sfr_rd),
        .sfr_wr       (sfr_wr),
        .sfr_wdata    (sfr_wdata),
        .rd_data      (rd_data)
    );

    dspace_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .waddr (ram_waddr),
        .wdata (ram_wdata),
        .raddr (ram_raddr),
        .rdata (ram_rdata)
    );

endmodule

// File: rtl/dspace_router_chk.sv
module dspace_router_chk #(
    parameter int unsigned       ADDR_W   = 8,
    parameter int unsigned       DATA_W   = 8,
    parameter logic [DATA_W-1:0] FILL_VAL = '0
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] acc_addr,
    input logic              acc_indirect,
    input logic              acc_rd,
    input logic              acc_wr,
    input logic              stk_push,
    input logic              stk_pop,
    input logic [DATA_W-1:0] rd_data,
    input logic [ADDR_W-1:0] stk_ptr,
    input logic [ADDR_W-1:0] sfr_addr,
    input logic              sfr_rd,
    input logic              sfr_wr,
    input logic              sfr_hit,
    input logic              ram_we
);
    logic plain_upper;
    assign plain_upper = (acc_rd || acc_wr) && !stk_push && !stk_pop && acc_addr[ADDR_W-1];

    a_r2_direct_to_bus: assert property (@(posedge clk) disable iff (rst)
        plain_upper && !acc_indirect |->
            !ram_we && sfr_addr == acc_addr && sfr_wr == acc_wr && sfr_rd == acc_rd);

    a_r3_indirect_no_bus: assert property (@(posedge clk) disable iff (rst)
        plain_upper && acc_indirect |-> !sfr_rd && !sfr_wr);

    a_r5_unclaimed_fill: assert property (@(posedge clk) disable iff (rst)
        sfr_rd && !sfr_hit |-> rd_data == FILL_VAL);

    a_r8_push_step: assert property (@(posedge clk) disable iff (rst)
        stk_push |=> stk_ptr == ADDR_W'($past(stk_ptr) + 1'b1));

    a_r9_pop_step: assert property (@(posedge clk) disable iff (rst)
        stk_pop && !stk_push |=> stk_ptr == ADDR_W'($past(stk_ptr) - 1'b1));

    a_r11_stack_blocks_bus: assert property (@(posedge clk) disable iff (rst)
        (stk_push || stk_pop) |-> !sfr_rd && !sfr_wr);

    a_r12_idle_fill: assert property (@(posedge clk) disable iff (rst)
        !acc_rd && !stk_pop |-> rd_data == FILL_VAL);

endmodule

bind dspace_router dspace_router_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .FILL_VAL (FILL_VAL)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .acc_addr     (acc_addr),
    .acc_indirect (acc_indirect),
    .acc_rd       (acc_rd),
    .acc_wr       (acc_wr),
    .stk_push     (stk_push),
    .stk_pop      (stk_pop),
    .rd_data      (rd_data),
    .stk_ptr      (stk_ptr),
    .sfr_addr     (sfr_addr),
    .sfr_rd       (sfr_rd),
    .sfr_wr       (sfr_wr),
    .sfr_hit      (sfr_hit),
    .ram_we       (ram_we)
);

// File: tb/dspace_router_tb.sv
module dspace_router_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] acc_addr;
    logic       acc_indirect, acc_rd, acc_wr;
    logic [7:0] acc_wdata;
    logic       stk_push, stk_pop;
    logic [7:0] rd_data, stk_ptr, sfr_addr, sfr_wdata, sfr_rdata;
    logic       sfr_rd, sfr_wr, sfr_hit;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    dspace_router u_dut (
        .clk(clk), .rst(rst), .acc_addr(acc_addr), .acc_indirect(acc_indirect),
        .acc_rd(acc_rd), .acc_wr(acc_wr), .acc_wdata(acc_wdata),
        .stk_push(stk_push), .stk_pop(stk_pop), .rd_data(rd_data), .stk_ptr(stk_ptr),
        .sfr_addr(sfr_addr), .sfr_rd(sfr_rd), .sfr_wr(sfr_wr), .sfr_wdata(sfr_wdata),
        .sfr_rdata(sfr_rdata), .sfr_hit(sfr_hit)
    );

    // Peripheral model: one register at A0H, nothing else claims an address
    logic [7:0] periph_a0;
    always_ff @(posedge clk) begin
        if (rst) periph_a0 <= 8'h00;
        else if (sfr_wr && sfr_addr == 8'hA0) periph_a0 <= sfr_wdata;
    end
    assign sfr_hit   = (sfr_rd || sfr_wr) && sfr_addr == 8'hA0;
    assign sfr_rdata = periph_a0;

    // Vector: tag[3:0] op[1:0](0 idle,1 write,2 read) ind addr wdata expected_rd
    localparam int NV = 12;
    localparam logic [30:0] VEC [NV] = '{
        {4'd1,  2'd1, 1'b0, 8'h10, 8'h55, 8'h00},  // R1 direct write low
        {4'd1,  2'd2, 1'b1, 8'h10, 8'h00, 8'h55},  // R1 indirect read back
        {4'd3,  2'd1, 1'b1, 8'hA0, 8'h3C, 8'h00},  // R3 indirect write upper
        {4'd2,  2'd1, 1'b0, 8'hA0, 8'hC3, 8'h00},  // R2 direct write to bus
        {4'd4,  2'd2, 1'b1, 8'hA0, 8'h00, 8'h3C},  // R4 upper RAM kept
        {4'd5,  2'd2, 1'b0, 8'hA0, 8'h00, 8'hC3},  // R5 claimed read
        {4'd5,  2'd2, 1'b0, 8'hB5, 8'h00, 8'h00},  // R5 unclaimed fill
        {4'd3,  2'd1, 1'b1, 8'hFF, 8'h99, 8'h00},  // R3 top byte write
        {4'd6,  2'd2, 1'b1, 8'hFF, 8'h00, 8'h99},  // R6 read next cycle
        {4'd1,  2'd1, 1'b1, 8'h7F, 8'h11, 8'h00},  // R1 indirect write low
        {4'd1,  2'd2, 1'b0, 8'h7F, 8'h00, 8'h11},  // R1 direct read back
        {4'd12, 2'd0, 1'b0, 8'h33, 8'hFF, 8'h00}   // R12 idle
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic push, input logic pop, input logic rd, input logic wr,
                         input logic ind, input logic [7:0] addr, input logic [7:0] wd);
        @(negedge clk);
        stk_push = push; stk_pop = pop; acc_rd = rd; acc_wr = wr;
        acc_indirect = ind; acc_addr = addr; acc_wdata = wd;
        #1;
    endtask

    task automatic idle();
        drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        stk_push = 0; stk_pop = 0; acc_rd = 0; acc_wr = 0;
        acc_indirect = 0; acc_addr = 0; acc_wdata = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R7 reset pointer", stk_ptr, 8'h07);
        check("R12 reset rd_data", rd_data, 8'h00);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            logic [30:0] v;
            logic        up;
            string       tag;
            v   = VEC[i];
            up  = v[23];
            tag = $sformatf("R%0d vec%0d", v[30:27], i);
            drive(1'b0, 1'b0, v[26:25] == 2'd2, v[26:25] == 2'd1, v[24], v[23:16], v[15:8]);
            check(tag, rd_data, v[7:0]);
            check({tag, " sfr_wr"}, 8'(sfr_wr), 8'(v[26:25] == 2'd1 && !v[24] && up));
            check({tag, " sfr_rd"}, 8'(sfr_rd), 8'(v[26:25] == 2'd2 && !v[24] && up));
        end

        // R8: push lands at pointer+1, pointer advances after the edge
        drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'hAA);
        check("R8 pointer before edge", stk_ptr, 8'h07);
        idle();
        check("R8 pointer after push", stk_ptr, 8'h08);
        drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'h08, 8'h00);
        check("R8 pushed byte", rd_data, 8'hAA);

        // R9: pop data in the same cycle, pointer retreats
        drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00);
        check("R9 pop data", rd_data, 8'hAA);
        idle();
        check("R9 pointer after pop", stk_ptr, 8'h07);

        // R10: climb to FFH, then wrap to 00H and back
        for (int k = 0; k < 248; k++) begin
            drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'(k));
        end
        idle();
        check("R10 pointer at top", stk_ptr, 8'hFF);
        drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'hFF, 8'h00);
        check("R10 byte at FFH", rd_data, 8'hF7);
        drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h5A);
        idle();
        check("R10 pointer wrapped up", stk_ptr, 8'h00);
        drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'h00, 8'h00);
        check("R10 byte at 00H", rd_data, 8'h5A);
        drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00);
        check("R10 pop at 00H", rd_data, 8'h5A);
        idle();
        check("R10 pointer wrapped down", stk_ptr, 8'hFF);

        // R11: push beats a direct register write in the same cycle
        drive(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'hA0, 8'h12);
        check("R11 no sfr_wr under push", 8'(sfr_wr), 8'h00);
        drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'hA0, 8'h00);
        check("R11 register untouched", rd_data, 8'hC3);
        check("R11 pointer advanced", stk_ptr, 8'h00);
        // R11: pop beats a direct register read
        drive(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'hA0, 8'h00);
        check("R11 pop data wins", rd_data, 8'h12);
        check("R11 no sfr_rd under pop", 8'(sfr_rd), 8'h00);
        idle();
        check("R12 idle rd_data", rd_data, 8'h00);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule